// File: doc/BRIEF.md
# Integer Condition Evaluation Unit

This block decides whether a conditional branch or a conditional move is taken. It has two modes, chosen by `mode_reg`. In flag mode it takes two sets of integer condition flags (negative, zero, overflow, carry). One set describes a 32-bit result and the other a 64-bit result. `use_wide` picks one set, and a 4-bit code picks one of sixteen predicates over it. In register mode it tests a 64-bit operand against zero with a 3-bit code. The test looks at the operand's sign bit and at whether the operand is zero.

The decision and an illegal-code flag are registered. Both appear one clock after the inputs are presented. The flags themselves, the branch target and any annul or prediction hints are produced elsewhere in the pipeline.

Top module: `cond_eval_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `taken` and `bad_sel` are 0 after that edge.
- R2: `taken` and `bad_sel` show the function of the inputs sampled at the previous rising edge, and nothing earlier.
- R3: In flag mode (`mode_reg`=0), `use_wide`=1 evaluates `flags_wide` and `use_wide`=0 evaluates `flags_narrow`. Each flag vector is {N,Z,V,C}, with N at bit 3, Z at bit 2, V at bit 1 and C at bit 0.
- R4: Flag code 8 (always) gives `taken`=1 and code 0 (never) gives `taken`=0, whatever the flags are.
- R5: Code 1 (eq) is Z, and code 9 (ne) is not Z. Code 10 (gt) is not (Z or (N xor V)), and code 2 (le) is Z or (N xor V).
- R6: Code 11 (ge) is not (N xor V), and code 3 (lt) is N xor V.
- R7: Code 12 (gu) is not (C or Z), and code 4 (leu) is C or Z. Code 13 (cc) is not C, and code 5 (cs) is C.
- R8: Code 14 (pos) is not N, and code 6 (neg) is N. Code 15 (vc) is not V, and code 7 (vs) is V.
- R9: In register mode (`mode_reg`=1), `reg_cond` 1 is "value is zero" and 5 is "value is non-zero". Code 3 is "bit 63 set" and code 7 is "bit 63 clear".
- R10: In register mode, `reg_cond` 2 is "bit 63 set or value zero", and 6 is "bit 63 clear and value non-zero".
- R11: In register mode, `reg_cond` 0 or 4 gives `bad_sel`=1 and `taken`=0. In flag mode `bad_sel` is always 0.
- R12: In register mode the flag inputs, `use_wide` and `flag_cond` have no effect on the outputs. In flag mode `reg_value` and `reg_cond` have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_reg | input | 1 | 1 = register-versus-zero test, 0 = flag predicate |
| use_wide | input | 1 | Flag mode: 1 = use the 64-bit result flags |
| flags_narrow | input | 4 | Flags of the 32-bit result, {N,Z,V,C} |
| flags_wide | input | 4 | Flags of the 64-bit result, {N,Z,V,C} |
| flag_cond | input | 4 | Flag predicate code |
| reg_value | input | 64 | Operand tested in register mode |
| reg_cond | input | 3 | Register test code |
| taken | output | 1 | Registered condition result |
| bad_sel | output | 1 | Registered illegal register-test code |

## Verification
The outputs are registered, so a fault in the predicate table, in the flag-set multiplexer or in the zero and sign detection shows as a wrong `taken` exactly one cycle after the stimulus. A fault that swaps the flag sets shows only when the two sets disagree. The stimulus therefore draws them independently, and directed cases set them to opposite values. A stuck reserved-code decode shows on `bad_sel` in that same cycle. The zero detector is probed with single-bit operands as well as zero and all-ones.

// File: rtl/cond_eval_pkg.sv
package cond_eval_pkg;

  localparam int FLAG_COND_W = 4;
  localparam int REG_COND_W  = 3;
  localparam int NUM_FLAG_PRED = 1 << FLAG_COND_W;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } cc_flags_t;

  typedef enum logic [FLAG_COND_W-1:0] {
    FC_NEVER  = 4'd0,
    FC_EQ     = 4'd1,
    FC_LE     = 4'd2,
    FC_LT     = 4'd3,
    FC_LEU    = 4'd4,
    FC_CS     = 4'd5,
    FC_NEG    = 4'd6,
    FC_VS     = 4'd7,
    FC_ALWAYS = 4'd8,
    FC_NE     = 4'd9,
    FC_GT     = 4'd10,
    FC_GE     = 4'd11,
    FC_GU     = 4'd12,
    FC_CC     = 4'd13,
    FC_POS    = 4'd14,
    FC_VC     = 4'd15
  } flag_cond_e;

  typedef enum logic [REG_COND_W-1:0] {
    RT_RSV0 = 3'd0,
    RT_Z    = 3'd1,
    RT_LEZ  = 3'd2,
    RT_LZ   = 3'd3,
    RT_RSV4 = 3'd4,
    RT_NZ   = 3'd5,
    RT_GZ   = 3'd6,
    RT_GEZ  = 3'd7
  } reg_cond_e;

  // Each predicate is written out on its own, so that the complementary
  // pairs can be cross-checked against one another.
  function automatic logic eval_flag_pred(input logic [FLAG_COND_W-1:0] code,
                                          input cc_flags_t f);
    logic r;
    case (flag_cond_e'(code))
      FC_NEVER:  r = 1'b0;
      FC_EQ:     r = f.z;
      FC_LE:     r = f.z | (f.n ^ f.v);
      FC_LT:     r = f.n ^ f.v;
      FC_LEU:    r = f.c | f.z;
      FC_CS:     r = f.c;
      FC_NEG:    r = f.n;
      FC_VS:     r = f.v;
      FC_ALWAYS: r = 1'b1;
      FC_NE:     r = ~f.z;
      FC_GT:     r = ~f.z & ~(f.n ^ f.v);
      FC_GE:     r = (f.n & f.v) | (~f.n & ~f.v);
      FC_GU:     r = ~f.c & ~f.z;
      FC_CC:     r = ~f.c;
      FC_POS:    r = ~f.n;
      FC_VC:     r = ~f.v;
      default:   r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cc_set_mux.sv
module cc_set_mux
  import cond_eval_pkg::*;
(
  input  cc_flags_t narrow_i,
  input  cc_flags_t wide_i,
  input  logic      wide_sel_i,
  output cc_flags_t flags_o
);

  always_comb begin
    flags_o = wide_sel_i ? wide_i : narrow_i;
  end

endmodule

// File: rtl/flag_pred_eval.sv
module flag_pred_eval
  import cond_eval_pkg::*;
(
  input  cc_flags_t               flags_i,
  input  logic [FLAG_COND_W-1:0]  code_i,
  output logic                    hit_o
);

  localparam int HALF = NUM_FLAG_PRED / 2;

  logic [NUM_FLAG_PRED-1:0] pred;

  for (genvar i = 0; i < NUM_FLAG_PRED; i++) begin : g_pred
    assign pred[i] = eval_flag_pred(FLAG_COND_W'(i), flags_i);
  end

  assign hit_o = pred[code_i];

  // Upper half of the code space is the complement of the lower half.
  always_comb begin
    for (int k = 0; k < HALF; k++) begin
      AST_PRED_PAIRS: assert (pred[k + HALF] == ~pred[k]) else $error("complement pair mismatch"); // R5
    end
    AST_ALWAYS_NEVER: assert (pred[HALF] && !pred[0]) else $error("always/never wrong"); // R4
  end

endmodule

// File: rtl/reg_zero_test.sv
module reg_zero_test
  import cond_eval_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0]      value_i,
  input  logic [REG_COND_W-1:0]  code_i,
  output logic                   hit_o,
  output logic                   illegal_o
);

  localparam int SIGN_BIT = DATA_W - 1;

  logic is_zero;
  logic is_neg;

  assign is_zero = (value_i == '0);
  assign is_neg  = value_i[SIGN_BIT];

  always_comb begin
    hit_o     = 1'b0;
    illegal_o = 1'b0;
    case (reg_cond_e'(code_i))
      RT_Z:    hit_o = is_zero;
      RT_LEZ:  hit_o = is_neg | is_zero;
      RT_LZ:   hit_o = is_neg;
      RT_NZ:   hit_o = ~is_zero;
      RT_GZ:   hit_o = ~is_neg & ~is_zero;
      RT_GEZ:  hit_o = ~is_neg;
      default: illegal_o = 1'b1;
    endcase
  end

  always_comb begin
    AST_RSV_NO_HIT: assert (!(illegal_o && hit_o)) else $error("reserved code produced a hit"); // R11
    AST_NEG_NONZERO: assert (!(is_neg && is_zero)) else $error("sign and zero both set"); // R10
  end

endmodule

// File: rtl/cond_eval_unit.sv
module cond_eval_unit
  import cond_eval_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   mode_reg,
  input  logic                   use_wide,
  input  logic [3:0]             flags_narrow,
  input  logic [3:0]             flags_wide,
  input  logic [3:0]             flag_cond,
  input  logic [DATA_W-1:0]      reg_value,
  input  logic [2:0]             reg_cond,
  output logic                   taken,
  output logic                   bad_sel
);

  cc_flags_t sel_flags;
  logic      flag_hit;
  logic      reg_hit;
  logic      reg_illegal;
  logic      taken_d;
  logic      bad_d;

  cc_set_mux u_mux (
    .narrow_i   (cc_flags_t'(flags_narrow)),
    .wide_i     (cc_flags_t'(flags_wide)),
    .wide_sel_i (use_wide),
    .flags_o    (sel_flags)
  );

  flag_pred_eval u_flag (
    .flags_i (sel_flags),
    .code_i  (flag_cond),
    .hit_o   (flag_hit)
  );

  reg_zero_test #(.DATA_W(DATA_W)) u_reg (
    .value_i   (reg_value),
    .code_i    (reg_cond),
    .hit_o     (reg_hit),
    .illegal_o (reg_illegal)
  );

  always_comb begin
    if (mode_reg) begin
      taken_d = reg_hit & ~reg_illegal;
      bad_d   = reg_illegal;
    end else begin
      taken_d = flag_hit;
      bad_d   = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      taken   <= 1'b0;
      bad_sel <= 1'b0;
    end else begin
      taken   <= taken_d;
      bad_sel <= bad_d;
    end
  end

  AST_RST_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!taken && !bad_sel)) else $error("outputs not cleared by reset"); // R1
  AST_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (!mode_reg && flag_cond == 4'd8) |=> taken) else $error("always not taken"); // R4
  AST_NEVER_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!mode_reg && flag_cond == 4'd0) |=> !taken) else $error("never was taken"); // R4
  AST_RSV_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    (mode_reg && reg_cond[1:0] == 2'b00) |=> (bad_sel && !taken)) else $error("reserved code missed"); // R11
  AST_FLAG_MODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    !mode_reg |=> !bad_sel) else $error("bad_sel in flag mode"); // R11
  AST_REG_ZERO_HIT: assert property (@(posedge clk) disable iff (rst)
    (mode_reg && reg_cond == 3'd1 && reg_value == '0) |=> taken) else $error("zero test missed"); // R9

endmodule

// File: tb/test_cond_eval_unit.sv
`timescale 1ns/1ps
module test_cond_eval_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_reg = 1'b0;
  logic        use_wide = 1'b0;
  logic [3:0]  flags_narrow = '0;
  logic [3:0]  flags_wide = '0;
  logic [3:0]  flag_cond = '0;
  logic [63:0] reg_value = '0;
  logic [2:0]  reg_cond = '0;
  logic        taken;
  logic        bad_sel;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cond_eval_unit i_cond_eval_unit (
    .clk, .rst, .mode_reg, .use_wide, .flags_narrow, .flags_wide,
    .flag_cond, .reg_value, .reg_cond, .taken, .bad_sel
  );

  function automatic bit model_flag(input logic [3:0] f, input logic [3:0] c);
    bit n = f[3], z = f[2], v = f[1], cy = f[0];
    case (c)
      4'd0:  return 0;
      4'd8:  return 1;
      4'd1:  return z;
      4'd9:  return !z;
      4'd2:  return z || (n != v);
      4'd10: return !z && (n == v);
      4'd3:  return n != v;
      4'd11: return n == v;
      4'd4:  return cy || z;
      4'd12: return !cy && !z;
      4'd5:  return cy;
      4'd13: return !cy;
      4'd6:  return n;
      4'd14: return !n;
      4'd7:  return v;
      default: return !v;
    endcase
  endfunction

  function automatic bit model_reg(input logic [63:0] x, input logic [2:0] c);
    bit zero = (x == 64'd0);
    bit neg = x[63];
    case (c)
      3'd1: return zero;
      3'd5: return !zero;
      3'd3: return neg;
      3'd7: return !neg;
      3'd2: return neg || zero;
      3'd6: return !neg && !zero;
      default: return 0;
    endcase
  endfunction

  function automatic string req_of(input bit m, input logic [3:0] fc, input logic [2:0] rc);
    if (m) begin
      if (rc == 3'd0 || rc == 3'd4) return "R11";
      if (rc == 3'd2 || rc == 3'd6) return "R10";
      return "R9";
    end
    case (fc)
      4'd0, 4'd8: return "R4";
      4'd1, 4'd9, 4'd2, 4'd10: return "R5";
      4'd3, 4'd11: return "R6";
      4'd4, 4'd12, 4'd5, 4'd13: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string req, input logic got, input logic exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  // Drive at a falling edge, let one rising edge register it, check at the next falling edge (R2).
  task automatic apply(input bit m, input bit w, input logic [3:0] fn, input logic [3:0] fw,
                       input logic [3:0] fc, input logic [63:0] rv, input logic [2:0] rc,
                       input string req);
    logic [3:0] fs;
    bit et, eb;
    @(negedge clk);
    mode_reg = m; use_wide = w; flags_narrow = fn; flags_wide = fw;
    flag_cond = fc; reg_value = rv; reg_cond = rc;
    fs = w ? fw : fn;
    et = m ? model_reg(rv, rc) : model_flag(fs, fc);
    eb = m && (rc == 3'd0 || rc == 3'd4);
    @(negedge clk);
    check(req, taken, et);
    check(req, bad_sel, eb);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    // R1: inputs that would give taken=1 while reset is held
    mode_reg = 1'b0; flag_cond = 4'd8;
    repeat (3) @(negedge clk);
    check("R1", taken, 1'b0);
    check("R1", bad_sel, 1'b0);
    rst = 1'b0;
    // R2: the output follows a change one cycle later, not before
    apply(0, 0, 4'h0, 4'h0, 4'd8, 64'd0, 3'd0, "R2");
    @(negedge clk);
    flag_cond = 4'd0;
    #1 check("R2", taken, 1'b1);
    @(negedge clk);
    check("R2", taken, 1'b0);
    // R3: the two flag sets disagree
    apply(0, 0, 4'b0100, 4'b0000, 4'd1, 64'd0, 3'd0, "R3");
    apply(0, 1, 4'b0100, 4'b0000, 4'd1, 64'd0, 3'd0, "R3");
    apply(0, 1, 4'b0000, 4'b0001, 4'd5, 64'd0, 3'd0, "R3");
    apply(0, 0, 4'b0000, 4'b0001, 4'd5, 64'd0, 3'd0, "R3");
    // R4: always/never against every flag value
    for (int f = 0; f < 16; f++) begin
      apply(0, f[0], 4'(f), 4'(15 - f), 4'd8, 64'd0, 3'd0, "R4");
      apply(0, f[0], 4'(f), 4'(15 - f), 4'd0, 64'd0, 3'd0, "R4");
    end
    // R5-R8: every code against every flag value
    for (int c = 1; c < 16; c++) begin
      for (int f = 0; f < 16; f++) begin
        apply(0, 1, 4'(~f), 4'(f), 4'(c), 64'd0, 3'd0, req_of(0, 4'(c), 3'd0));
      end
    end
    // R9/R10: boundary operands
    for (int rc = 0; rc < 8; rc++) begin
      apply(1, 0, 4'h0, 4'h0, 4'd0, 64'd0, 3'(rc), req_of(1, 4'd0, 3'(rc)));
      apply(1, 0, 4'h0, 4'h0, 4'd0, 64'd1, 3'(rc), req_of(1, 4'd0, 3'(rc)));
      apply(1, 0, 4'h0, 4'h0, 4'd0, 64'h8000_0000_0000_0000, 3'(rc), req_of(1, 4'd0, 3'(rc)));
      apply(1, 0, 4'h0, 4'h0, 4'd0, '1, 3'(rc), req_of(1, 4'd0, 3'(rc)));
      apply(1, 0, 4'h0, 4'h0, 4'd0, 64'h7fff_ffff_ffff_ffff, 3'(rc), req_of(1, 4'd0, 3'(rc)));
    end
    for (int b = 0; b < 64; b++) begin
      apply(1, 0, 4'h0, 4'h0, 4'd0, 64'd1 << b, 3'd1, "R9");
    end
    // R11: reserved codes with flags that would otherwise be taken
    apply(1, 1, 4'hf, 4'hf, 4'd8, 64'd0, 3'd0, "R11");
    apply(1, 1, 4'hf, 4'hf, 4'd8, 64'd0, 3'd4, "R11");
    // R12: irrelevant inputs changed, outputs unchanged
    apply(1, 0, 4'h0, 4'h0, 4'd0, 64'd0, 3'd1, "R12");
    apply(1, 1, 4'hf, 4'h4, 4'd0, 64'd0, 3'd1, "R12");
    apply(0, 0, 4'b0100, 4'h0, 4'd1, 64'd0, 3'd0, "R12");
    apply(0, 0, 4'b0100, 4'h0, 4'd1, '1, 3'd6, "R12");
    // Random mix
    for (int i = 0; i < 3000; i++) begin
      bit m = 1'($urandom);
      logic [3:0] fc = 4'($urandom);
      logic [2:0] rc = 3'($urandom);
      logic [63:0] rv = {$urandom, $urandom};
      if ($urandom_range(0, 3) == 0) rv = '0;
      apply(m, 1'($urandom), 4'($urandom), 4'($urandom), fc, rv, rc, req_of(m, fc, rc));
    end
    // R1: reset in mid-run
    @(negedge clk);
    mode_reg = 0; flag_cond = 4'd8; rst = 1'b1;
    @(negedge clk);
    check("R1", taken, 1'b0);
    rst = 1'b0;
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule